// File: doc/BRIEF.md
# Sixteen-bit ALU with latched compare flags

This block is the arithmetic and logic unit of a small CPU datapath. Two 16-bit unsigned operands and a 4-bit operation code produce a 16-bit result with no clock in the path. The result covers addition, subtraction, multiplication, unsigned division, the three bitwise operations, logical shifts in both directions and a move that passes the second operand through unchanged.

Alongside the result the block keeps three condition flags: equal, below and above. They compare the two operands as unsigned numbers. They are loaded on a rising clock edge only while a compare-enable input is high, and they then hold until the next compare, whatever operations run in between. This lets a compare instruction set up a later conditional branch on equal, less-than or greater-than. Sign handling, overflow and carry are not produced.

Top module: `alu16_flags`

## Requirements
- R1: With op = 4'h0 the result is (a + b) modulo 2^16, in the same cycle.
- R2: With op = 4'h1 the result is (a - b) modulo 2^16, so a smaller a wraps around.
- R3: With op = 4'h2 the result is the low 16 bits of the full product a * b.
- R4: With op = 4'h3 the result is the unsigned quotient a / b; when b is zero the result is 16'hFFFF.
- R5: With op = 4'h4, 4'h5 and 4'h6 the result is a AND b, a OR b and a XOR b respectively.
- R6: With op = 4'h7 the result is a shifted left by b bits, and with op = 4'h8 a shifted right logically by b bits; any b of 16 or more gives zero.
- R7: On a rising edge with cmp_en high, flag_eq, flag_lt and flag_gt load (a == b), (a < b) and (a > b) as unsigned values, so exactly one is set after the edge.
- R8: On a rising edge with cmp_en low the three flags keep their values, whatever op, a and b are.
- R9: With op = 4'h9 the result equals b unchanged.
- R10: While rst_n is low the three flags are cleared.
- R11: Codes 4'hA to 4'hF give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op | input | 4 | Operation code |
| a | input | 16 | First operand |
| b | input | 16 | Second operand (also shift amount) |
| cmp_en | input | 1 | Loads the flags from a and b at the next rising edge |
| result | output | 16 | Combinational result |
| flag_eq | output | 1 | Last compare found a equal to b |
| flag_lt | output | 1 | Last compare found a below b |
| flag_gt | output | 1 | Last compare found a above b |

## Verification
The result is combinational, so it is due in the very cycle its operands are applied, and the flags are due one rising edge later. Each stimulus records its expected result tagged with the current cycle and its expected flag triple tagged with the following cycle, even when no compare is made, so every hold is checked too. The monitor samples one nanosecond after each falling edge and retires only the expectations whose cycle has come, well clear of the edge on which the flags change.

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int WIDTH = 16,
  parameter int OPW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPW-1:0]   op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cmp_en,
  output logic [WIDTH-1:0] result,
  output logic             flag_eq,
  output logic             flag_lt,
  output logic             flag_gt
);
  localparam int SHW = $clog2(WIDTH);

  localparam logic [OPW-1:0] OP_ADD = 'd0;
  localparam logic [OPW-1:0] OP_SUB = 'd1;
  localparam logic [OPW-1:0] OP_MUL = 'd2;
  localparam logic [OPW-1:0] OP_DIV = 'd3;
  localparam logic [OPW-1:0] OP_AND = 'd4;
  localparam logic [OPW-1:0] OP_OR  = 'd5;
  localparam logic [OPW-1:0] OP_XOR = 'd6;
  localparam logic [OPW-1:0] OP_SHL = 'd7;
  localparam logic [OPW-1:0] OP_SHR = 'd8;
  localparam logic [OPW-1:0] OP_MOV = 'd9;

  logic [2*WIDTH-1:0] prod;
  logic [WIDTH-1:0]   quot;
  logic               shift_out;
  logic [SHW-1:0]     shamt;

  assign prod      = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};
  assign quot      = (b == '0) ? '1 : a / b;
  assign shift_out = |b[WIDTH-1:SHW];
  assign shamt     = b[SHW-1:0];

  always_comb begin
    case (op)
      OP_ADD:  result = a + b;
      OP_SUB:  result = a - b;
      OP_MUL:  result = prod[WIDTH-1:0];
      OP_DIV:  result = quot;
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_SHL:  result = shift_out ? '0 : a << shamt;
      OP_SHR:  result = shift_out ? '0 : a >> shamt;
      OP_MOV:  result = b;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_eq <= 1'b0;
      flag_lt <= 1'b0;
      flag_gt <= 1'b0;
    end else if (cmp_en) begin
      flag_eq <= (a == b);
      flag_lt <= (a < b);
      flag_gt <= (a > b);
    end
  end
endmodule

module alu16_flags_chk #(
  parameter int WIDTH = 16,
  parameter int OPW   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OPW-1:0]   op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cmp_en,
  input logic [WIDTH-1:0] result,
  input logic             flag_eq,
  input logic             flag_lt,
  input logic             flag_gt
);
  localparam logic [OPW-1:0] C_DIV = 'd3;
  localparam logic [OPW-1:0] C_MOV = 'd9;

  a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |=> $countones({flag_eq, flag_lt, flag_gt}) == 1);

  a_r7_eq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |=> flag_eq == ($past(a) == $past(b)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable({flag_eq, flag_lt, flag_gt}));

  a_r4_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op == C_DIV && b == '0) |-> result == '1);

  a_r9_move: assert property (@(posedge clk) disable iff (!rst_n)
    (op == C_MOV) |-> result == b);

  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |-> {flag_eq, flag_lt, flag_gt} == 3'b000);
endmodule

bind alu16_flags alu16_flags_chk #(.WIDTH(WIDTH), .OPW(OPW)) u_chk (.*);

// File: tb/tb_alu16_flags.sv
`timescale 1ns/1ps
module tb_alu16_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cmp_en = 1'b0;
  logic [15:0] res;
  logic        feq, flt, fgt;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct {
    int          due;
    bit          is_flag;
    logic [15:0] val;
    string       tag;
  } item_t;
  item_t sb[$];

  logic [2:0] mflags = 3'b000;

  alu16_flags dut (
    .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .cmp_en(cmp_en),
    .result(res), .flag_eq(feq), .flag_lt(flt), .flag_gt(fgt)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] expect_res(logic [3:0] o, logic [15:0] x, logic [15:0] y);
    logic [31:0] p;
    case (o)
      4'h0: return x + y;
      4'h1: return x - y;
      4'h2: begin p = 32'(x) * 32'(y); return p[15:0]; end
      4'h3: return (y == 0) ? 16'hFFFF : x / y;
      4'h4: return x & y;
      4'h5: return x | y;
      4'h6: return x ^ y;
      4'h7: return (y >= 16) ? 16'h0 : x << y;
      4'h8: return (y >= 16) ? 16'h0 : x >> y;
      4'h9: return y;
      default: return 16'h0;
    endcase
  endfunction

  task automatic step(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                      input logic c, input string rtag, input string ftag);
    item_t it;
    @(negedge clk);
    op = o; a = x; b = y; cmp_en = c;
    it.due = cyc; it.is_flag = 1'b0; it.val = expect_res(o, x, y); it.tag = rtag;
    sb.push_back(it);
    if (c) mflags = {x == y, x < y, x > y};
    it.due = cyc + 1; it.is_flag = 1'b1; it.val = {13'b0, mflags}; it.tag = ftag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        act = it.is_flag ? {13'b0, feq, flt, fgt} : res;
        checks++;
        if (act !== it.val) begin
          fails++;
          $display("FAIL %s: %s actual=%h expected=%h", it.tag,
                   it.is_flag ? "flags" : "result", act, it.val);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : driver
    cmp_en = 1'b1; a = 16'd4; b = 16'd4;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({feq, flt, fgt} !== 3'b000) begin
      fails++;
      $display("FAIL R10: flags in reset actual=%b expected=000", {feq, flt, fgt});
    end
    @(negedge clk);
    cmp_en = 1'b0;
    rst_n = 1'b1;
    step(4'h0, 16'd0, 16'd0, 1'b0, "R1", "R10");
    step(4'h0, 16'd1200, 16'd34, 1'b0, "R1", "R8");
    step(4'h0, 16'hFFFF, 16'd2, 1'b0, "R1", "R8");
    step(4'h1, 16'd3, 16'd5, 1'b0, "R2", "R8");
    step(4'h1, 16'd500, 16'd123, 1'b0, "R2", "R8");
    step(4'h2, 16'h1234, 16'h0100, 1'b0, "R3", "R8");
    step(4'h2, 16'd300, 16'd7, 1'b0, "R3", "R8");
    step(4'h3, 16'd100, 16'd7, 1'b0, "R4", "R8");
    step(4'h3, 16'hFFFF, 16'd1, 1'b0, "R4", "R8");
    step(4'h3, 16'd55, 16'd0, 1'b0, "R4", "R8");
    step(4'h4, 16'hF0F0, 16'h3C3C, 1'b0, "R5", "R8");
    step(4'h5, 16'hF0F0, 16'h3C3C, 1'b0, "R5", "R8");
    step(4'h6, 16'hF0F0, 16'h3C3C, 1'b0, "R5", "R8");
    step(4'h7, 16'd8, 16'd3, 1'b0, "R6", "R8");
    step(4'h7, 16'd8, 16'd1, 1'b0, "R6", "R8");
    step(4'h8, 16'd8, 16'd3, 1'b0, "R6", "R8");
    step(4'h8, 16'd8, 16'd1, 1'b0, "R6", "R8");
    step(4'h7, 16'h0001, 16'd15, 1'b0, "R6", "R8");
    step(4'h8, 16'h8000, 16'd15, 1'b0, "R6", "R8");
    step(4'h7, 16'hFFFF, 16'd16, 1'b0, "R6", "R8");
    step(4'h8, 16'hFFFF, 16'd17, 1'b0, "R6", "R8");
    step(4'h7, 16'h00FF, 16'h0104, 1'b0, "R6", "R8");
    step(4'h9, 16'h1111, 16'hBEEF, 1'b0, "R9", "R8");
    step(4'hA, 16'h1234, 16'h5678, 1'b0, "R11", "R8");
    step(4'hF, 16'hFFFF, 16'hFFFF, 1'b0, "R11", "R8");
    step(4'h0, 16'd9, 16'd9, 1'b1, "R1", "R7");
    step(4'h1, 16'd3, 16'd5, 1'b0, "R2", "R8");
    step(4'h0, 16'd3, 16'd5, 1'b1, "R1", "R7");
    step(4'h9, 16'd7, 16'd7, 1'b0, "R9", "R8");
    step(4'h6, 16'd5, 16'd3, 1'b1, "R5", "R7");
    step(4'h0, 16'h8000, 16'd1, 1'b1, "R1", "R7");
    step(4'h3, 16'd1, 16'h8000, 1'b1, "R4", "R7");
    step(4'h2, 16'd2, 16'd2, 1'b0, "R3", "R8");
    step(4'hC, 16'd0, 16'hFFFF, 1'b0, "R11", "R8");
    step(4'h0, 16'hABCD, 16'hABCD, 1'b1, "R1", "R7");
    step(4'h1, 16'd0, 16'd1, 1'b0, "R2", "R8");
    @(negedge clk);
    cmp_en = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    if (sb.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule